// File: doc/BRIEF.md
# Triangular PWM Timebase

This block generates a symmetric up/down count that downstream compare units use to place PWM edges for a power inverter. Once started it climbs from zero to a programmable peak, descends back to zero, and repeats, so every carrier period is centred on the peak. The live count, the current direction, and a reload strobe are exported so compare logic can update its own shadowed thresholds at the same instant as the peak.

Software controls the block through a small write-only port. A control word holds the run bit, a clock-divide selector and an interrupt decimation field. The peak value is double-buffered. Software writes a shadow copy at any time, and that copy moves into the active peak register only when a decimated zero-crossing interrupt fires. While the block is stopped, the active peak register can also be loaded directly. The count value itself cannot be read or written by software.

Top module: `tri_timebase`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up), the interrupt and reload outputs are 0, and both the active peak and its shadow hold 255.
- R2: Address 0 is the control word: bit 0 runs the block, bits [3:1] select the count rate and bits [6:4] set the decimation. For a selector value s, the count advances once every 2^s clocks. Values 6 and 7 behave as 5. The first advance happens on the 2^s-th rising edge after the edge that wrote the run bit, starting from 0.
- R3: While counting up, a count equal to the active peak makes the next advance go down. countDown is 1 exactly while the count is below the peak on the way down.
- R4: An advance that brings the count to 0 while going down is an underflow, and the advance after it goes up again.
- R5: With decimation field n, underflowIrq pulses for one clock on every (n+1)-th underflow counted since the run bit was last set. The pulse starts at the edge where the count becomes 0.
- R6: On each interrupt pulse the shadow peak is copied into the active peak, and reloadStb pulses in the same clock.
- R7: A write to address 1 loads the shadow peak from wrData[9:0]. A value of zero is ignored.
- R8: A write to address 2 loads the active peak from wrData[9:0] only while the block is stopped. While running, or when the value is zero, the write is ignored.
- R9: Clearing the run bit forces the count to 0 and the direction to up on the next clock, and restarts both the divider phase and the underflow tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrAddr | input | 2 | Register address: 0 control, 1 shadow peak, 2 direct peak |
| wrData | input | 16 | Write data |
| count | output | 10 | Live triangular count |
| countDown | output | 1 | 1 while the count is descending |
| underflowIrq | output | 1 | Decimated underflow interrupt pulse |
| reloadStb | output | 1 | Pulse marking the peak reload |

## Verification
A wrong peak, direction or divider state shows at the count output within one carrier period as a turn at the wrong value or an advance at the wrong clock. This is often within a handful of clocks at small peaks. A wrong underflow tally shows only at the next expected interrupt. For that reason, runs span several decimation cycles and start right after a run that left the tally nonzero. A reload with the wrong value appears as a wrong turning point in the period that follows the interrupt.

// File: rtl/tri_timebase_pkg.sv
`timescale 1ns/1ps
package tri_timebase_pkg;
  parameter int TB_CNT_W = 10;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_BUF  = 2'd1,
    ADDR_PER  = 2'd2
  } tbAddr_e;

  typedef struct packed {
    logic                tick;
    logic                clear;
    logic                reload;
    logic [TB_CNT_W-1:0] reloadVal;
    logic                directLoad;
    logic [TB_CNT_W-1:0] directVal;
  } tbStrobe_t;
endpackage

// File: rtl/tri_timebase_control.sv
`timescale 1ns/1ps
module tri_timebase_control
  import tri_timebase_pkg::*;
#(
  parameter int                  DataW       = 16,
  parameter int                  SelW        = 3,
  parameter int                  DivW        = 3,
  parameter int                  PreMax      = 5,
  parameter logic [TB_CNT_W-1:0] ResetPeriod = 10'h0FF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic             underflowIn,
  output tbStrobe_t        strobe,
  output logic             irqOut
);
  localparam int PreCntW = PreMax;
  localparam int SelLo   = 1;
  localparam int SelHi   = SelW;
  localparam int DivLo   = SelW + 1;
  localparam int DivHi   = SelW + DivW;

  logic                enableQ;
  logic [SelW-1:0]     selQ;
  logic [DivW-1:0]     divQ;
  logic [DivW-1:0]     tallyQ;
  logic [TB_CNT_W-1:0] bufferQ;
  logic [PreCntW-1:0]  preCntQ;

  logic [SelW-1:0]     selEff;
  logic [PreCntW-1:0]  preMask;
  logic [TB_CNT_W-1:0] wrVal;
  logic                ctrlWr, bufWr, perWr, tallyHit;

  always_comb begin
    wrVal    = wrData[TB_CNT_W-1:0];
    ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
    bufWr    = wrEn && (wrAddr == ADDR_BUF);
    perWr    = wrEn && (wrAddr == ADDR_PER);
    selEff   = (selQ > SelW'(PreMax)) ? SelW'(PreMax) : selQ;
    preMask  = PreCntW'((1 << selEff) - 1);
    tallyHit = underflowIn && (tallyQ == divQ);

    strobe.tick       = enableQ && ((preCntQ & preMask) == preMask);
    strobe.clear      = !enableQ;
    strobe.reload     = tallyHit;
    strobe.reloadVal  = bufferQ;
    strobe.directLoad = perWr && !enableQ && (wrVal != '0);
    strobe.directVal  = wrVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      selQ    <= '0;
      divQ    <= '0;
      bufferQ <= ResetPeriod;
      preCntQ <= '0;
      tallyQ  <= '0;
      irqOut  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enableQ <= wrData[0];
        selQ    <= wrData[SelHi:SelLo];
        divQ    <= wrData[DivHi:DivLo];
      end
      if (bufWr && (wrVal != '0)) bufferQ <= wrVal;
      preCntQ <= enableQ ? preCntQ + 1'b1 : '0;
      if (!enableQ)         tallyQ <= '0;
      else if (underflowIn) tallyQ <= tallyHit ? '0 : tallyQ + 1'b1;
      irqOut <= tallyHit;
    end
  end

  assert_irq_follows_uf_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(underflowIn));

  assert_shadow_nonzero_R7: assert property (@(posedge clk) disable iff (!rstN)
    bufferQ != '0);
endmodule

// File: rtl/tri_timebase_datapath.sv
`timescale 1ns/1ps
module tri_timebase_datapath
  import tri_timebase_pkg::*;
#(
  parameter logic [TB_CNT_W-1:0] ResetPeriod = 10'h0FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  tbStrobe_t           strobe,
  output logic [TB_CNT_W-1:0] countOut,
  output logic                downOut,
  output logic                underflow,
  output logic                reloadOut
);
  logic [TB_CNT_W-1:0] countQ, periodQ, nextCount;
  logic                downQ, goingDown;

  always_comb begin
    goingDown = downQ || (countQ >= periodQ);
    nextCount = goingDown ? countQ - 1'b1 : countQ + 1'b1;
    underflow = strobe.tick && !strobe.clear && goingDown
                && (countQ == TB_CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= '0;
      downQ     <= 1'b0;
      periodQ   <= ResetPeriod;
      reloadOut <= 1'b0;
    end else begin
      if (strobe.clear) begin
        countQ <= '0;
        downQ  <= 1'b0;
      end else if (strobe.tick) begin
        countQ <= nextCount;
        downQ  <= goingDown && !underflow;
      end
      if (strobe.directLoad)  periodQ <= strobe.directVal;
      else if (strobe.reload) periodQ <= strobe.reloadVal;
      reloadOut <= strobe.reload;
    end
  end

  assign countOut = countQ;
  assign downOut  = downQ;

  assert_count_within_R3: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= periodQ);

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.clear) |=>
      (countQ == TB_CNT_W'($past(countQ) + 1'b1)) ||
      (countQ == TB_CNT_W'($past(countQ) - 1'b1)));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.clear) |=> $stable(countQ));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (countQ == '0) && !downQ);

  assert_uf_turns_R4: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> (countQ == '0) && !downQ);

  assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && !strobe.directLoad) |=> periodQ == $past(strobe.reloadVal));
endmodule

// File: rtl/tri_timebase.sv
`timescale 1ns/1ps
module tri_timebase
  import tri_timebase_pkg::*;
#(
  parameter int                  DataW       = 16,
  parameter int                  SelW        = 3,
  parameter int                  DivW        = 3,
  parameter int                  PreMax      = 5,
  parameter logic [TB_CNT_W-1:0] ResetPeriod = 10'h0FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [DataW-1:0]    wrData,
  output logic [TB_CNT_W-1:0] count,
  output logic                countDown,
  output logic                underflowIrq,
  output logic                reloadStb
);
  tbStrobe_t strobe;
  logic      underflow;

  tri_timebase_control #(
    .DataW(DataW), .SelW(SelW), .DivW(DivW),
    .PreMax(PreMax), .ResetPeriod(ResetPeriod)
  ) u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .underflowIn(underflow), .strobe(strobe), .irqOut(underflowIrq)
  );

  tri_timebase_datapath #(
    .ResetPeriod(ResetPeriod)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .countOut(count), .downOut(countDown),
    .underflow(underflow), .reloadOut(reloadStb)
  );
endmodule

// File: tb/tri_timebase_bench.sv
`timescale 1ns/1ps
module tri_timebase_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [9:0]  count;
  logic        countDown, underflowIrq, reloadStb;

  typedef struct packed {
    logic [9:0] cnt;
    logic       down;
    logic       irq;
    logic       rel;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    errors = 0;

  always #2.5 clk = ~clk;

  tri_timebase u_tri_timebase (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .countDown(countDown),
    .underflowIrq(underflowIrq), .reloadStb(reloadStb)
  );

  task automatic compare(string tag, exp_t e);
    checks++;
    if (count !== e.cnt || countDown !== e.down ||
        underflowIrq !== e.irq || reloadStb !== e.rel) begin
      errors++;
      $display("FAIL %s: got count=%0d down=%0b irq=%0b reload=%0b, expected count=%0d down=%0b irq=%0b reload=%0b",
               tag, count, countDown, underflowIrq, reloadStb,
               e.cnt, e.down, e.irq, e.rel);
    end
  endtask

  // Monitor: pops one expected item per clock, sampled mid-cycle.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t  e;
      string tg;
      e  = expQ.pop_front();
      tg = tagQ.pop_front();
      compare(tg, e);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk);
    #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  // Driver: programs a run, then pushes per-clock expectations derived
  // from the requirements (tick every 2^s clocks, triangle of the peak).
  task automatic scenario(input bit doWrites, input int dirP, input int bufP,
                          input int sel, input int div, input int n,
                          input bit poke, input string tag);
    int selEff, d, curP, shadow, pos, uf;
    bit tk, irq;
    wr(2'd0, 16'd0);
    if (doWrites) begin
      wr(2'd2, 16'(dirP));
      wr(2'd2, 16'd0);          // R8: zero direct write ignored
      wr(2'd1, 16'(bufP));
    end
    curP   = doWrites ? dirP : 255;
    shadow = doWrites ? bufP : 255;
    wr(2'd0, 16'(div * 16 + sel * 2 + 1));
    selEff = (sel > 5) ? 5 : sel;
    d   = 1 << selEff;
    pos = 0;
    uf  = 0;
    for (int t = 0; t < n; t++) begin
      exp_t e;
      tk  = (t >= 1) && (t % d == 0);
      irq = 1'b0;
      if (tk) begin
        pos++;
        if (pos == 2 * curP) begin
          pos = 0;
          uf++;
          if (uf % (div + 1) == 0) begin
            irq  = 1'b1;
            curP = shadow;
          end
        end
      end
      e.cnt  = 10'((pos <= curP) ? pos : 2 * curP - pos);
      e.down = (pos > curP);
      e.irq  = irq;
      e.rel  = irq;
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
    if (poke) begin
      wr(2'd2, 16'd7);          // R8: ignored while running
      wr(2'd1, 16'd0);          // R7: zero shadow write ignored
    end
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    exp_t z;
    z = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    compare("R1 reset state", z);

    // R1 R2 R3 R4: default peak 255, full rate
    scenario(1'b0, 0, 0, 0, 0, 1030, 1'b0, "R1 R2 R3 R4 default peak");
    // R6 R7 R8: peak 3, shadow 5, writes while running are ignored
    scenario(1'b1, 3, 5, 0, 0, 40, 1'b1, "R6 R7 R8 reload and ignored writes");

    // R9: stop mid-run
    wr(2'd0, 16'd0);
    @(posedge clk);
    @(negedge clk);
    compare("R9 stop clears count", z);
    repeat (5) @(negedge clk);
    compare("R9 stays cleared", z);

    // R2 R5: divide by 4, every third underflow, leaves tally at 1
    scenario(1'b1, 4, 4, 2, 2, 132, 1'b0, "R2 R5 decimate by 3");
    // R5 R9: tally restarted by the stop before this run
    scenario(1'b1, 2, 2, 1, 2, 52, 1'b0, "R5 R9 tally restart");
    // R2 R5 R6: selector 7 acts as 5, reload to 3 on second underflow
    scenario(1'b1, 2, 3, 7, 1, 460, 1'b0, "R2 R5 R6 clamp selector");
    // R3 R4: peak of 1
    scenario(1'b1, 1, 1, 3, 0, 70, 1'b0, "R3 R4 minimum peak");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R1 watchdog: run still active after 200000 cycles, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule